// File: doc/BRIEF.md
# Indirect Register Bridge with Toggle Handshake

This block gives a host access to two internal register spaces, one for a PLL and one for a PHY, through a small window of host registers. Both spaces use 8-bit byte offsets on a 4-byte stride and carry 32-bit data. The window holds three registers:

- a control word, which carries the target offset, the direction and the handshake bits;
- a write-data register;
- a read-data register.

The control word can be written directly. It can also be changed through set, clear and invert aliases, so that software can change single bits without a read-modify-write.

Software prepares an access by loading the offset and the direction into the control word. It then inverts the request bit of the target it wants. The bridge sees that the request bit and the acknowledge bit of that target now differ, and runs one access on that target's bus: a one-cycle strobe, followed by a wait for ready. When the access finishes, the bridge stores the read data if the access was a read, then copies the request bit into the acknowledge bit. Software polls until the two bits are equal again.

A control bit that is active low holds the whole indirect interface in reset.

Top module: `ind_reg_bridge`

## Requirements
- R1: After `rst_n` is released, the control word, the write-data register and the read-data register all read 0, and both strobes are low.
- R2: Host window word indices:
  - 0 writes the control word directly.
  - 1 ORs the written data into the control word.
  - 2 clears every control bit written as 1.
  - 3 inverts every control bit written as 1.
  - 4 is the write-data register.
  - 5 is the read-data register, which is read only.
  - Indices 0 to 3 all read back the control word. Every other index reads 0.
  - Control word fields: [7:0] target offset, [15] interface enable (0 holds the interface in reset), [24] PLL request, [25] PLL acknowledge, [26] PHY request, [27] PHY acknowledge, [31] direction (1 is read, 0 is write). All other bits read 0.
- R3: Host writes never change the acknowledge bits [25] and [27], whichever index is used.
- R4: When no access is in flight and a target's request bit differs from its acknowledge bit, that target's strobe is high for exactly one cycle, starting one cycle after the control word shows the mismatch. If both targets are pending at once, the PLL is served first.
- R5: While a strobe is high, `tgt_addr` equals control bits [7:0] and `tgt_we` equals the inverse of bit [31], both as they stood when the access launched. `tgt_wdata` is the write-data register as it stood at launch.
- R6: An access completes in the first cycle in which the selected target's ready is high. That cycle may be the strobe cycle. From the next cycle, the target's acknowledge bit equals its request bit. Ready from the target that is not selected has no effect.
- R7: A completing read stores the selected target's read data in the read-data register. A completing write leaves the read-data register unchanged.
- R8: While an access is in flight, host writes to the request bits [24] and [26] are ignored. All other writable bits still update.
- R9: While control bit [15] is 0, bits [27:24] read 0, any access in flight is abandoned and no strobe is raised. Setting bit [15] again starts no access.
- R10: At most one of the two strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 3 | Host window word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| pll_stb | output | 1 | PLL access strobe |
| phy_stb | output | 1 | PHY access strobe |
| tgt_we | output | 1 | Access is a write |
| tgt_addr | output | 8 | Target register offset |
| tgt_wdata | output | 32 | Target write data |
| pll_ready | input | 1 | PLL access finished |
| pll_rdata | input | 32 | PLL read data |
| phy_ready | input | 1 | PHY access finished |
| phy_rdata | input | 32 | PHY read data |

## Verification
If the in-flight flag is wrong, it shows in the cycle after the error, as a missing or extra strobe or as a request bit that accepts or refuses a write it should not. If the selected target is wrong, the wrong acknowledge bit follows its request, and the wrong read data is stored one edge after ready. The reference model tracks the control word, both strobes and the latched access fields, and compares them every clock. A divergence is therefore reported within one cycle of the edge that caused it.

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        pll_stb,
  output logic        phy_stb,
  output logic        tgt_we,
  output logic [7:0]  tgt_addr,
  output logic [31:0] tgt_wdata,
  input  logic        pll_ready,
  input  logic [31:0] pll_rdata,
  input  logic        phy_ready,
  input  logic [31:0] phy_rdata
);
  localparam logic [31:0] IMPL_M = 32'h8500_80FF;
  localparam logic [31:0] ACK_M  = 32'h0A00_0000;
  localparam logic [31:0] REQ_M  = 32'h0500_0000;

  logic [31:0] ctrl_q, ctrl_w, ctrl_n, wdat_q, rdat_q, wout_q;
  logic [7:0]  addr_q;
  logic        busy_q, sel_q, dir_q, pll_stb_q, phy_stb_q;

  wire ctl_hit  = host_we && (host_addr < 3'd4);
  wire pll_pend = ctrl_q[24] ^ ctrl_q[25];
  wire phy_pend = ctrl_q[26] ^ ctrl_q[27];
  wire rdy      = sel_q ? phy_ready : pll_ready;
  wire done     = busy_q && rdy;
  wire launch   = !busy_q && (pll_pend || phy_pend);
  wire [31:0] keep = ACK_M | (busy_q ? REQ_M : 32'h0);

  always_comb begin
    case (host_addr[1:0])
      2'd0:    ctrl_w = host_wdata;
      2'd1:    ctrl_w = ctrl_q | host_wdata;
      2'd2:    ctrl_w = ctrl_q & ~host_wdata;
      default: ctrl_w = ctrl_q ^ host_wdata;
    endcase
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctl_hit) ctrl_n = (ctrl_w & IMPL_M & ~keep) | (ctrl_q & keep);
    if (done) begin
      if (sel_q) ctrl_n[27] = ctrl_q[26];
      else       ctrl_n[25] = ctrl_q[24];
    end
    if (!ctrl_n[15]) ctrl_n[27:24] = 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; wdat_q <= '0; rdat_q <= '0; wout_q <= '0; addr_q <= '0;
      busy_q <= 1'b0; sel_q <= 1'b0; dir_q <= 1'b0;
      pll_stb_q <= 1'b0; phy_stb_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      if (host_we && host_addr == 3'd4) wdat_q <= host_wdata;
      if (done && dir_q) rdat_q <= sel_q ? phy_rdata : pll_rdata;
      pll_stb_q <= 1'b0;
      phy_stb_q <= 1'b0;
      if (!ctrl_n[15] || done) begin
        busy_q <= 1'b0;
      end else if (launch) begin
        busy_q    <= 1'b1;
        sel_q     <= !pll_pend;
        dir_q     <= ctrl_q[31];
        addr_q    <= ctrl_q[7:0];
        wout_q    <= wdat_q;
        pll_stb_q <= pll_pend;
        phy_stb_q <= !pll_pend;
      end
    end
  end

  always_comb begin
    case (host_addr)
      3'd0, 3'd1, 3'd2, 3'd3: host_rdata = ctrl_q;
      3'd4:    host_rdata = wdat_q;
      3'd5:    host_rdata = rdat_q;
      default: host_rdata = 32'h0;
    endcase
  end

  assign pll_stb   = pll_stb_q;
  assign phy_stb   = phy_stb_q;
  assign tgt_we    = !dir_q;
  assign tgt_addr  = addr_q;
  assign tgt_wdata = wout_q;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pll_stb_q, phy_stb_q}));
  assert_pll_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_stb_q |=> !pll_stb_q);
  assert_phy_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_stb_q |=> !phy_stb_q);
  assert_pll_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_stb_q |-> $past(ctrl_q[24] != ctrl_q[25]));
  assert_pll_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15] && $past(ctrl_q[15]) && ctrl_q[25] != $past(ctrl_q[25])) |-> $past(pll_ready));
  assert_phy_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15] && $past(ctrl_q[15]) && ctrl_q[27] != $past(ctrl_q[27])) |-> $past(phy_ready));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && ctrl_q[15]) |-> (ctrl_q[24] == $past(ctrl_q[24]) && ctrl_q[26] == $past(ctrl_q[26])));
  assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[15] |=> (!pll_stb_q && !phy_stb_q));
endmodule

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic        pll_stb, phy_stb, tgt_we;
  logic [7:0]  tgt_addr;
  logic [31:0] tgt_wdata, pll_rdata, phy_rdata;
  logic        pll_ready = 1'b0, phy_ready = 1'b0;

  assign pll_rdata = 32'h5100_0000 | {24'h0, tgt_addr};
  assign phy_rdata = 32'h7E00_0000 | {24'h0, tgt_addr};

  ind_reg_bridge u_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pll_stb(pll_stb),
    .phy_stb(phy_stb), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .pll_ready(pll_ready), .pll_rdata(pll_rdata), .phy_ready(phy_ready), .phy_rdata(phy_rdata));

  int total = 0, bad = 0, cycles = 0;
  int lat = 0, cnt = 0;
  bit pend = 0, pend_t = 0, spur_phy = 0;

  logic [31:0] m_ctrl = 0, m_wd = 0, m_rd = 0, m_wo = 0;
  logic [7:0]  m_ad = 0;
  bit m_busy = 0, m_sel = 0, m_dir = 0, m_sp = 0, m_sh = 0;

  always @(posedge clk) begin : model
    logic [31:0] v, nc, keep;
    bit pp, hp, rdy, dn, ln;
    if (!rst_n) begin
      m_ctrl = 0; m_wd = 0; m_rd = 0; m_wo = 0; m_ad = 0;
      m_busy = 0; m_sel = 0; m_dir = 0; m_sp = 0; m_sh = 0;
    end else begin
      pp = m_ctrl[24] != m_ctrl[25];
      hp = m_ctrl[26] != m_ctrl[27];
      rdy = m_sel ? phy_ready : pll_ready;
      dn = m_busy && rdy;
      ln = !m_busy && (pp || hp);
      nc = m_ctrl;
      if (host_we && host_addr < 3'd4) begin
        case (host_addr)
          3'd0: v = host_wdata;
          3'd1: v = m_ctrl | host_wdata;
          3'd2: v = m_ctrl & ~host_wdata;
          default: v = m_ctrl ^ host_wdata;
        endcase
        keep = 32'h0A00_0000 | (m_busy ? 32'h0500_0000 : 32'h0);
        nc = (v & 32'h8500_80FF & ~keep) | (m_ctrl & keep);
      end
      if (dn) begin
        if (m_sel) nc[27] = m_ctrl[26]; else nc[25] = m_ctrl[24];
        if (m_dir) m_rd = m_sel ? phy_rdata : pll_rdata;
      end
      m_sp = 0; m_sh = 0;
      if (dn) m_busy = 0;
      else if (ln) begin
        m_busy = 1; m_sel = !pp; m_dir = m_ctrl[31]; m_ad = m_ctrl[7:0];
        m_wo = m_wd; m_sp = pp; m_sh = !pp;
      end
      if (!nc[15]) begin nc[27:24] = 0; m_busy = 0; m_sp = 0; m_sh = 0; end
      if (host_we && host_addr == 3'd4) m_wd = host_wdata;
      m_ctrl = nc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_view(input logic [2:0] a);
    if (a < 3'd4) return m_ctrl;
    if (a == 3'd4) return m_wd;
    if (a == 3'd5) return m_rd;
    return 32'h0;
  endfunction

  task automatic compare();
    chk(pll_stb == m_sp, "R4 pll strobe", {31'h0, pll_stb}, {31'h0, m_sp});
    chk(phy_stb == m_sh, "R4 phy strobe", {31'h0, phy_stb}, {31'h0, m_sh});
    chk(!(pll_stb && phy_stb), "R10 single strobe", {30'h0, pll_stb, phy_stb}, 32'h0);
    if (m_sp || m_sh) begin
      chk(tgt_addr == m_ad, "R5 target offset", {24'h0, tgt_addr}, {24'h0, m_ad});
      chk(tgt_we == !m_dir, "R5 target direction", {31'h0, tgt_we}, {31'h0, !m_dir});
      chk(tgt_wdata == m_wo, "R5 target write data", tgt_wdata, m_wo);
    end
    chk(host_rdata == m_view(host_addr), "R2 window read", host_rdata, m_view(host_addr));
  endtask

  task automatic respond();
    pll_ready = 1'b0;
    phy_ready = spur_phy;
    if (pend) begin
      if (cnt <= 1) begin
        pend = 0;
        if (pend_t) phy_ready = 1'b1; else pll_ready = 1'b1;
      end else cnt--;
    end
    if (pll_stb || phy_stb) begin
      if (lat == 0) begin
        if (phy_stb) phy_ready = 1'b1; else pll_ready = 1'b1;
      end else begin
        pend = 1; cnt = lat; pend_t = phy_stb;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    respond();
    cycles++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    step();
    host_we = 1'b0; host_addr = 3'd0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
    host_addr = a;
    #1;
    chk(host_rdata == exp, tag, host_rdata, exp);
    host_addr = 3'd0;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    peek(3'd0, 32'h0, "R1 control after reset");
    peek(3'd4, 32'h0, "R1 write data after reset");
    peek(3'd5, 32'h0, "R1 read data after reset");
    chk(!pll_stb && !phy_stb, "R1 strobes idle", {30'h0, pll_stb, phy_stb}, 32'h0);

    // enable interface, PLL write with latency 2
    hw(3'd0, 32'h0000_8000);
    hw(3'd4, 32'h1234_5678);
    hw(3'd1, 32'h0000_0010);
    lat = 2;
    hw(3'd3, 32'h0100_0000);
    idle(6);
    peek(3'd0, 32'h0300_8010, "R6 PLL ack follows request");

    // PHY read completing in the strobe cycle
    hw(3'd2, 32'h0000_00FF);
    hw(3'd1, 32'h8000_0024);
    lat = 0;
    hw(3'd3, 32'h0400_0000);
    idle(5);
    peek(3'd0, 32'h8F00_8024, "R6 PHY ack follows request");
    peek(3'd5, 32'h7E00_0024, "R7 read data captured");

    // PLL write, toggle while in flight, spurious PHY ready
    hw(3'd2, 32'h8000_0000);
    lat = 5; spur_phy = 1;
    hw(3'd3, 32'h0100_0000);
    idle(1);
    hw(3'd3, 32'h0100_0000);
    hw(3'd1, 32'h0000_0003);
    idle(8);
    spur_phy = 0;
    idle(2);
    peek(3'd0, 32'h0C00_8027, "R8 request ignored while in flight; R6 other ready ignored");
    peek(3'd5, 32'h7E00_0024, "R7 write leaves read data");

    // R3 ack bits not writable
    hw(3'd1, 32'h0A00_0000);
    peek(3'd0, 32'h0C00_8027, "R3 set alias on ack bits");
    hw(3'd2, 32'h0800_0000);
    hw(3'd3, 32'h0200_0000);
    peek(3'd0, 32'h0C00_8027, "R3 clear/invert alias on ack bits");

    // both pending: PLL first
    lat = 1;
    hw(3'd3, 32'h0500_0000);
    idle(10);
    peek(3'd0, 32'h0300_8027, "R4 both served");

    // interface reset mid-access
    lat = 10;
    hw(3'd3, 32'h0400_0000);
    idle(2);
    hw(3'd2, 32'h0000_8000);
    peek(3'd0, 32'h0000_0027, "R9 handshake bits forced low");
    hw(3'd3, 32'h0100_0000);
    peek(3'd0, 32'h0000_0027, "R9 request held low while off");
    idle(14);
    hw(3'd1, 32'h0000_8000);
    idle(3);
    peek(3'd0, 32'h0000_8027, "R9 no access after re-enable");

    // direct write of all ones, two reads
    peek(3'd6, 32'h0, "R2 unused index reads zero");
    lat = 0;
    hw(3'd0, 32'hFFFF_FFFF);
    peek(3'd0, 32'h8500_80FF, "R2 implemented bits only");
    idle(8);
    peek(3'd0, 32'h8F00_80FF, "R4 two reads served");
    peek(3'd5, 32'h7E00_00FF, "R7 last read is PHY");
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule